// File: doc/BRIEF.md
# ECC Read-Modify-Write Engine

This block sits inside a memory device, between a 32-bit external access port and an internal array whose words are wider and are protected by an extended Hamming code (single-error correct, double-error detect). Each 32-bit access selects one slice of a wider data word of 64 or 128 bits. Sharing the check bits across the whole word keeps the parity overhead low: 8 check bits for 64 data bits, 9 for 128.

A read fetches the full codeword and decodes it. The engine corrects or flags any error and returns the addressed slice. A write always starts with an internal fetch. The engine repairs a single-bit error in the fetched word, replaces the addressed slice, computes fresh check bits and stores the whole codeword. After the store it keeps `busy` high for a programmable spacing window, because the next command also begins with an array read. A fault-injection mask is XORed into every stored codeword so that array cell faults can be modelled at the ports.

Top module: `ecc_rmw_engine`

## Requirements
- R1: After reset `busy`, `rd_valid`, `err_corrected` and `err_uncorrectable` are low, and every array word holds all-zero data with valid check bits, so a read returns zero with no flag.
- R2: `cmd_addr` is split into two fields. Its low SEL_W bits (SEL_W = log2(DATA_W/32)) pick slice k, which is data bits [32k+31:32k]. Its upper ADDR_W bits pick the array word. A read returns that slice on `rdata`.
- R3: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. For a read, `busy` is high for exactly 2 cycles after acceptance. `rd_valid` is a one-cycle pulse on the second edge after acceptance, and `busy` falls on that same edge.
- R4: A write replaces only the addressed 32-bit slice. The other slices of that word keep their (corrected) contents.
- R5: After a write is accepted, `busy` stays high for exactly 2 + WR_GAP cycles.
- R6: A command presented while `busy` is high is ignored and does not change the array.
- R7: When the stored codeword differs from a valid codeword in exactly one bit (data, Hamming check or overall parity), a read returns the correct slice with `err_corrected` high and `err_uncorrectable` low.
- R8: When exactly two bits differ, a read returns the slice of the stored, uncorrected data with `err_uncorrectable` high and `err_corrected` low.
- R9: A write to a word holding a single-bit error stores the corrected data merged with the new slice. A write to a word holding a double-bit error merges into the raw data. In both cases the word is stored with fresh, valid check bits.
- R10: The stored codeword is laid out as {overall parity, Hamming check bits, data}: bits [DATA_W-1:0] are data, then HR Hamming checks, and the top bit is overall parity. What is written equals the encoded word XOR `flip_mask`.
- R11: `err_corrected` and `err_uncorrectable` are low whenever `rd_valid` is low, and they are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W+SEL_W | Word address (upper bits) and slice select (low bits) |
| wdata | input | 32 | Write slice |
| flip_mask | input | CW_W | Bits inverted in the codeword stored by this write |
| busy | output | 1 | Engine occupied; commands ignored |
| rd_valid | output | 1 | Read data and flags valid for one cycle |
| rdata | output | 32 | Read slice |
| err_corrected | output | 1 | Single-bit error was corrected |
| err_uncorrectable | output | 1 | Double-bit error was detected |

## Verification
The bench builds the engine with a 128-bit data word, an 8-word array and a write spacing of 6 cycles. The wider word gives four slices and the 9-bit check field, so both the slice decode and the widest parity are exercised. The short spacing keeps each write cheap, which leaves room for several hundred random mixed operations. Fault masks with zero, one or two random bits reach every region of the codeword: data bits, Hamming check bits and the overall parity bit. The scrub-on-write and raw-merge paths are then exercised together with plain reads.

// File: rtl/ecc_rmw_engine.sv
module ecc_rmw_engine #(
  parameter int DATA_W = 64,
  parameter int EXT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int WR_GAP = 24,
  localparam int SLICES = DATA_W / EXT_W,
  localparam int SEL_W  = $clog2(SLICES),
  localparam int HR     = calc_hr(DATA_W),
  localparam int CW_W   = DATA_W + HR + 1,
  localparam int CA_W   = ADDR_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [CA_W-1:0]   cmd_addr,
  input  logic [EXT_W-1:0]  wdata,
  input  logic [CW_W-1:0]   flip_mask,
  output logic              busy,
  output logic              rd_valid,
  output logic [EXT_W-1:0]  rdata,
  output logic              err_corrected,
  output logic              err_uncorrectable
);

  function automatic int calc_hr(int d);
    int res = 0;
    for (int r = 1; r < 16; r++)
      if (res == 0 && (1 << r) >= d + r + 1) res = r;
    return res;
  endfunction

  function automatic int dpos(int i);
    int res = 0;
    int n = 0;
    for (int q = 3; q < 4096; q++)
      if ((q & (q - 1)) != 0) begin
        if (n == i) res = q;
        n++;
      end
    return res;
  endfunction

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(WR_GAP + 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK, S_HOLD} st_t;

  st_t               state;
  logic [CNT_W-1:0]  cnt;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SEL_W-1:0]  sel_q;
  logic [EXT_W-1:0]  wdata_q;
  logic [CW_W-1:0]   mask_q;
  logic [CW_W-1:0]   rd_word;
  logic [CW_W-1:0]   mem [DEPTH];
  logic [HR-1:0]     pos_tab [DATA_W];

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_pos
    assign pos_tab[gi] = HR'(dpos(gi));
  end

  logic [HR-1:0]     syn;
  logic              ovr_odd;
  logic              one_err;
  logic              two_err;
  logic [DATA_W-1:0] fixed;
  logic [DATA_W-1:0] merged;
  logic [HR-1:0]     new_chk;
  logic [CW_W-1:0]   new_word;

  always_comb begin
    syn = rd_word[DATA_W +: HR];
    for (int i = 0; i < DATA_W; i++)
      if (rd_word[i]) syn = syn ^ pos_tab[i];
    ovr_odd = ^rd_word;
    one_err = ovr_odd;
    two_err = !ovr_odd && (syn != '0);
    fixed = rd_word[DATA_W-1:0];
    for (int i = 0; i < DATA_W; i++)
      if (one_err && pos_tab[i] == syn) fixed[i] = ~fixed[i];
  end

  always_comb begin
    merged = fixed;
    merged[int'(sel_q) * EXT_W +: EXT_W] = wdata_q;
    new_chk = '0;
    for (int i = 0; i < DATA_W; i++)
      if (merged[i]) new_chk = new_chk ^ pos_tab[i];
    new_word = {^{new_chk, merged}, new_chk, merged} ^ mask_q;
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state             <= S_IDLE;
      cnt               <= '0;
      wr_q              <= 1'b0;
      addr_q            <= '0;
      sel_q             <= '0;
      wdata_q           <= '0;
      mask_q            <= '0;
      rd_word           <= '0;
      rd_valid          <= 1'b0;
      rdata             <= '0;
      err_corrected     <= 1'b0;
      err_uncorrectable <= 1'b0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      rd_valid          <= 1'b0;
      err_corrected     <= 1'b0;
      err_uncorrectable <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          wr_q    <= cmd_write;
          addr_q  <= cmd_addr[CA_W-1:SEL_W];
          sel_q   <= cmd_addr[SEL_W-1:0];
          wdata_q <= wdata;
          mask_q  <= flip_mask;
          state   <= S_FETCH;
        end
        S_FETCH: begin
          rd_word <= mem[addr_q];
          state   <= S_CHECK;
        end
        S_CHECK: if (wr_q) begin
          mem[addr_q] <= new_word;
          cnt         <= '0;
          state       <= S_HOLD;
        end else begin
          rd_valid          <= 1'b1;
          rdata             <= fixed[int'(sel_q) * EXT_W +: EXT_W];
          err_corrected     <= one_err;
          err_uncorrectable <= two_err;
          state             <= S_IDLE;
        end
        S_HOLD: begin
          if (cnt == CNT_W'(WR_GAP - 1)) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_FLAGS_ONLY_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !(err_corrected || err_uncorrectable)); // R11
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corrected && err_uncorrectable)); // R8
  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R3
  AST_RDV_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $past(busy))); // R3
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy); // R5
  AST_HOLD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) |-> (int'(cnt) < WR_GAP)); // R5

endmodule

// File: tb/ecc_rmw_engine_test.sv
module ecc_rmw_engine_test;
  localparam int DW = 128;
  localparam int AW = 3;
  localparam int GAP = 6;
  localparam int SW = 2;
  localparam int CW = DW + 9;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0;
  logic [AW+SW-1:0] cmd_addr = '0;
  logic [31:0] wdata = '0;
  logic [CW-1:0] flip_mask = '0;
  logic busy, rd_valid, err_corrected, err_uncorrectable;
  logic [31:0] rdata;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DW-1:0] ref_data [NW];
  logic [CW-1:0] ref_flip [NW];

  ecc_rmw_engine #(.DATA_W(DW), .EXT_W(32), .ADDR_W(AW), .WR_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .wdata(wdata), .flip_mask(flip_mask), .busy(busy),
    .rd_valid(rd_valid), .rdata(rdata), .err_corrected(err_corrected),
    .err_uncorrectable(err_uncorrectable));

  always #10 clk = ~clk;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(int w, int s, string req);
    int n = $countones(ref_flip[w]);
    logic [DW-1:0] raw = ref_data[w] ^ ref_flip[w][DW-1:0];
    logic [31:0] exp_d = (n == 2) ? raw[s*32 +: 32] : ref_data[w][s*32 +: 32];
    @(negedge clk);
    cmd_valid = 1; cmd_write = 0; cmd_addr = {AW'(w), SW'(s)};
    @(negedge clk);
    cmd_valid = 0;
    check(busy == 1, "R3 busy after read accept", 64'(busy), 1);
    @(negedge clk);
    check(rd_valid == 0 && busy == 1, "R3 no early rd_valid", 64'({rd_valid, busy}), 1);
    @(negedge clk);
    check(rd_valid == 1 && busy == 0, "R3 rd_valid pulse", 64'({rd_valid, busy}), 2);
    check(rdata == exp_d, {req, " R2 rdata"}, 64'(rdata), 64'(exp_d));
    check(err_corrected == (n == 1) && err_uncorrectable == (n == 2),
          {req, " R7 R8 flags"}, 64'({err_corrected, err_uncorrectable}),
          64'({n == 1, n == 2}));
    @(negedge clk);
    check(rd_valid == 0 && err_corrected == 0 && err_uncorrectable == 0,
          "R11 flags clear", 64'({rd_valid, err_corrected, err_uncorrectable}), 0);
  endtask

  task automatic do_write(int w, int s, logic [31:0] d, logic [CW-1:0] m, bit poke);
    int n = $countones(ref_flip[w]);
    int cyc = 0;
    logic [DW-1:0] base = (n == 2) ? (ref_data[w] ^ ref_flip[w][DW-1:0]) : ref_data[w];
    base[s*32 +: 32] = d;
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = {AW'(w), SW'(s)}; wdata = d; flip_mask = m;
    @(negedge clk);
    cmd_valid = 0; flip_mask = '0;
    while (busy && cyc < 100) begin
      cyc++;
      if (poke && cyc == 3) begin
        cmd_valid = 1; cmd_write = 1; wdata = ~d; flip_mask = '1;
      end else begin
        cmd_valid = 0; flip_mask = '0;
      end
      @(negedge clk);
    end
    cmd_valid = 0; flip_mask = '0;
    check(cyc == 2 + GAP, "R5 write busy length", 64'(cyc), 64'(2 + GAP));
    ref_data[w] = base;
    ref_flip[w] = m;
  endtask

  function automatic logic [CW-1:0] rand_mask(int nbits);
    logic [CW-1:0] m = '0;
    while ($countones(m) < nbits) m[$urandom_range(CW-1, 0)] = 1'b1;
    return m;
  endfunction

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < NW; i++) begin ref_data[i] = '0; ref_flip[i] = '0; end
    repeat (3) @(negedge clk);
    check(busy == 0 && rd_valid == 0 && err_corrected == 0 && err_uncorrectable == 0,
          "R1 outputs in reset", 64'({busy, rd_valid, err_corrected, err_uncorrectable}), 0);
    rst_n = 1;
    @(negedge clk);
    do_read(5, 2, "R1 zero after reset");
    for (int s = 0; s < 4; s++) do_write(1, s, 32'hA5A5_0000 + 32'(s * 17), '0, 0);
    for (int s = 0; s < 4; s++) do_read(1, s, "R2 R4 slice");
    do_write(1, 2, 32'h1234_5678, '0, 0);
    for (int s = 0; s < 4; s++) do_read(1, s, "R4 merge");
    do_write(2, 0, 32'hDEAD_BEEF, CW'(1) << 70, 0);
    do_read(2, 2, "R7 R10 data bit");
    do_write(2, 1, 32'h0F0F_0F0F, '0, 0);
    do_read(2, 2, "R9 scrubbed");
    do_write(3, 3, 32'hCAFE_F00D, CW'(1) << (DW + 4), 0);
    do_read(3, 3, "R7 R10 check bit");
    do_write(4, 0, 32'h8000_0001, CW'(1) << (CW - 1), 0);
    do_read(4, 0, "R7 R10 overall bit");
    do_write(6, 1, 32'h5555_AAAA, (CW'(1) << 33) | (CW'(1) << 100), 0);
    do_read(6, 1, "R8 double");
    do_read(6, 3, "R8 double raw");
    do_write(6, 0, 32'h1111_2222, '0, 0);
    do_read(6, 1, "R9 raw merge");
    do_read(6, 3, "R9 raw merge");
    do_write(7, 2, 32'h7777_7777, '0, 1);
    do_read(7, 2, "R6 ignored while busy");
    do_read(7, 0, "R6 ignored while busy");
    for (int k = 0; k < 300; k++) begin
      int w = $urandom_range(NW - 1, 0);
      int s = $urandom_range(3, 0);
      if ($urandom_range(1, 0) == 1) begin
        int r = $urandom_range(9, 0);
        int nb = (r < 6) ? 0 : ((r < 8) ? 1 : 2);
        do_write(w, s, $urandom, rand_mask(nb), 0);
      end else begin
        do_read(w, s, "R2 R7 R8 random");
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule